// File: doc/BRIEF.md
# Single-Step Debug Trap Sequencer

This block sits beside the retire stage of a small 32-bit core and turns a trace-enable bit in the status word into one debug trap per retired instruction. On each retirement it decides whether a trap is owed. If one is, it stalls the core and runs a fixed three-cycle entry. The first two cycles push the status word and the resume address onto the system stack. The third cycle lowers the stack pointer, clears the stack-select bit and sends the program counter to the trace vector.

Delayed branches need special handling. No trap is taken at the branch itself, because its delay slot has not run yet. The trap owed by the branch is delivered when the slot instruction retires, and the saved resume address then points past the slot. The core flags software-interrupt instructions and execution inside the trace handler, and neither is trapped. While tracing is on, the block also tells the interrupt controller to hold off both the non-maskable and the external interrupt. It tells the software-interrupt logic to raise no event of its own.

Top module: `trace_trap_seq`

## Requirements
- R1: A retirement (`ret_valid`=1 while `stall` was low) of an instruction that is not a delayed branch, while status bit `TRACE_BIT` (default 8) is 1 and `ret_excl`=0, starts a trap: `stall` goes high in that same cycle.
- R2: While status bit `TRACE_BIT` is 0 and no branch trap is owed, retirements start no trap and `stall` stays low.
- R3: A traced retirement with `ret_dbranch`=1 starts no trap. The trap is owed until the next retirement. If that retirement has `ret_in_slot`=1, a trap starts even when the trace bit has meanwhile been cleared, and it saves that slot's next address.
- R4: A retirement with `ret_excl`=1 (software-interrupt instruction, or code inside the trace handler) starts no trap.
- R5: In the cycle after the trap decision, `stk_we`=1 and the full status word, captured at the decision, is written to address SSP−4.
- R6: In the cycle after that, `stk_we`=1 and the next-instruction address is written to address SSP−8.
- R7: In the third cycle, `pc_we`, `ssp_we`, `ps_we` and `handler_enter` are 1 for exactly one cycle. `pc_out` = TBR + 0x3C4, `ssp_out` = SSP−8, and `ps_out` equals the captured status with bit `STK_SEL_BIT` (default 5) cleared.
- R8: `stall` stays high from the decision cycle through the redirect cycle. Retirements presented while the sequence is busy are ignored.
- R9: `irq_mask` and `swi_evt_block` are 1 exactly when status bit `TRACE_BIT` is 1.
- R10: During and directly after the synchronous active-low reset, all write strobes, `handler_enter` and `stall` are 0, and no branch trap is owed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_next_pc | input | 32 | Address of the instruction after the retiring one |
| ret_dbranch | input | 1 | Retiring instruction is a delayed branch |
| ret_in_slot | input | 1 | Retiring instruction sits in a delay slot |
| ret_excl | input | 1 | Retiring instruction is a software interrupt or runs in the trace handler |
| ps_in | input | 32 | Current status word |
| tbr_in | input | 32 | Table base register |
| ssp_in | input | 32 | System stack pointer |
| stk_we | output | 1 | Stack write strobe |
| stk_addr | output | 32 | Stack write byte address |
| stk_wdata | output | 32 | Stack write data |
| ssp_we | output | 1 | Load `ssp_out` into the stack pointer |
| ssp_out | output | 32 | New stack pointer |
| ps_we | output | 1 | Load `ps_out` into the status word |
| ps_out | output | 32 | New status word |
| pc_we | output | 1 | Redirect the program counter |
| pc_out | output | 32 | Trace vector address |
| handler_enter | output | 1 | One-cycle pulse marking entry into the handler |
| stall | output | 1 | Hold the core's retire stage |
| irq_mask | output | 1 | Mask non-maskable and external interrupts |
| swi_evt_block | output | 1 | Suppress software-interrupt events |

## Verification
The bench's main target is the delayed-branch case, in both forms. In one the slot is still traced. In the other the slot has cleared the trace bit. A design that traps at the branch would push the branch's own resume address, and one that forgets the owed trap would let the slot retire silently. It also retires traced instructions back to back and while the handler is active. A missing exclusion would re-enter the handler endlessly. A retirement presented mid-sequence would, in a faulty design, corrupt the saved return address or start a second frame. Push addresses, their order and the vector offset are compared cycle by cycle, so swapped pushes or an off-by-four stack pointer show up at once.

// File: rtl/trace_trap_pkg.sv
// Shared types and constants for the single-step trap sequencer.
package trace_trap_pkg;

    // Sequencer phases: idle, push status, push return address, redirect.
    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_PUSH_PS = 2'd1,
        SEQ_PUSH_RA = 2'd2,
        SEQ_REDIR   = 2'd3
    } seq_state_e;

    // Bytes per stack slot (one 32-bit word).
    localparam int unsigned SLOT_BYTES = 4;

endpackage

// File: rtl/trace_trap_gate.sv
// Decides per retirement whether a trace trap is taken.
// Assumes the core presents at most one retirement per cycle and that
// ret_in_slot is only set on the instruction right after a delayed branch.
module trace_trap_gate #(
    parameter int XLEN      = 32,
    parameter int TRACE_BIT = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            idle,
    input  logic            ret_valid,
    input  logic            ret_dbranch,
    input  logic            ret_in_slot,
    input  logic            ret_excl,
    input  logic [XLEN-1:0] ps_in,
    output logic            trace_on,
    output logic            take
);

    logic accept;
    logic owed_q;

    // Trace flag and acceptance of a retirement while not busy.
    always_comb begin
        trace_on = ps_in[TRACE_BIT];
        accept   = ret_valid & idle;
        take     = accept & ~ret_dbranch & ~ret_excl &
                   (trace_on | (owed_q & ret_in_slot));
    end

    // Remember a trap owed by a traced delayed branch until the next retirement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owed_q <= 1'b0;
        end else if (accept) begin
            owed_q <= trace_on & ret_dbranch & ~ret_excl;
        end
    end

endmodule

// File: rtl/trace_trap_ctl.sv
// Phase counter of the trap entry and snapshot of the values it needs.
// Assumes the core holds off retirements while stall is high.
module trace_trap_ctl
    import trace_trap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  logic [XLEN-1:0] ps_in,
    input  logic [XLEN-1:0] next_pc_in,
    input  logic [XLEN-1:0] ssp_in,
    input  logic [XLEN-1:0] tbr_in,
    output seq_state_e      state,
    output logic [XLEN-1:0] ps_q,
    output logic [XLEN-1:0] ra_q,
    output logic [XLEN-1:0] ssp_q,
    output logic [XLEN-1:0] tbr_q
);

    seq_state_e state_nx;

    // Next phase: leave idle on a trap decision, then step through fixed phases.
    always_comb begin
        unique case (state)
            SEQ_IDLE:    state_nx = take ? SEQ_PUSH_PS : SEQ_IDLE;
            SEQ_PUSH_PS: state_nx = SEQ_PUSH_RA;
            SEQ_PUSH_RA: state_nx = SEQ_REDIR;
            default:     state_nx = SEQ_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Snapshot of status, resume address, stack pointer and table base at the decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_q  <= '0;
            ra_q  <= '0;
            ssp_q <= '0;
            tbr_q <= '0;
        end else if (state == SEQ_IDLE && take) begin
            ps_q  <= ps_in;
            ra_q  <= next_pc_in;
            ssp_q <= ssp_in;
            tbr_q <= tbr_in;
        end
    end

endmodule

// File: rtl/trace_trap_frame.sv
// Drives the stack writes and the register updates of each entry phase.
// Purely combinational; assumes snapshots stay stable during the sequence.
module trace_trap_frame
    import trace_trap_pkg::*;
#(
    parameter int          XLEN        = 32,
    parameter int          STK_SEL_BIT = 5,
    parameter logic [31:0] VEC_OFFSET  = 32'h0000_03C4
) (
    input  seq_state_e      state,
    input  logic [XLEN-1:0] ps_q,
    input  logic [XLEN-1:0] ra_q,
    input  logic [XLEN-1:0] ssp_q,
    input  logic [XLEN-1:0] tbr_q,
    output logic            stk_we,
    output logic [XLEN-1:0] stk_addr,
    output logic [XLEN-1:0] stk_wdata,
    output logic            ssp_we,
    output logic [XLEN-1:0] ssp_out,
    output logic            ps_we,
    output logic [XLEN-1:0] ps_out,
    output logic            pc_we,
    output logic [XLEN-1:0] pc_out,
    output logic            handler_enter
);

    localparam logic [XLEN-1:0] STEP      = XLEN'(SLOT_BYTES);
    localparam logic [XLEN-1:0] FRAME     = XLEN'(2 * SLOT_BYTES);
    localparam logic [XLEN-1:0] SEL_CLEAR = ~(XLEN'(1) << STK_SEL_BIT);

    logic redir;

    // Per-phase outputs: two descending pushes, then the register loads.
    always_comb begin
        redir         = (state == SEQ_REDIR);
        stk_we        = (state == SEQ_PUSH_PS) || (state == SEQ_PUSH_RA);
        stk_addr      = (state == SEQ_PUSH_RA) ? (ssp_q - FRAME) : (ssp_q - STEP);
        stk_wdata     = (state == SEQ_PUSH_RA) ? ra_q : ps_q;
        ssp_we        = redir;
        ssp_out       = ssp_q - FRAME;
        ps_we         = redir;
        ps_out        = ps_q & SEL_CLEAR;
        pc_we         = redir;
        pc_out        = tbr_q + XLEN'(VEC_OFFSET);
        handler_enter = redir;
    end

endmodule

// File: rtl/trace_trap_seq.sv
// Top of the single-step debug trap sequencer: decision, phase control and
// frame generation. Assumes the core freezes retirement while stall is high.
module trace_trap_seq
    import trace_trap_pkg::*;
#(
    parameter int          XLEN        = 32,
    parameter int          TRACE_BIT   = 8,
    parameter int          STK_SEL_BIT = 5,
    parameter logic [31:0] VEC_OFFSET  = 32'h0000_03C4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ret_valid,
    input  logic [XLEN-1:0] ret_next_pc,
    input  logic            ret_dbranch,
    input  logic            ret_in_slot,
    input  logic            ret_excl,
    input  logic [XLEN-1:0] ps_in,
    input  logic [XLEN-1:0] tbr_in,
    input  logic [XLEN-1:0] ssp_in,
    output logic            stk_we,
    output logic [XLEN-1:0] stk_addr,
    output logic [XLEN-1:0] stk_wdata,
    output logic            ssp_we,
    output logic [XLEN-1:0] ssp_out,
    output logic            ps_we,
    output logic [XLEN-1:0] ps_out,
    output logic            pc_we,
    output logic [XLEN-1:0] pc_out,
    output logic            handler_enter,
    output logic            stall,
    output logic            irq_mask,
    output logic            swi_evt_block
);

    seq_state_e      state;
    logic            idle;
    logic            take;
    logic            trace_on;
    logic [XLEN-1:0] ps_q, ra_q, ssp_q, tbr_q;

    // Idle indication, core stall and the interrupt/software-event masks.
    always_comb begin
        idle          = (state == SEQ_IDLE);
        stall         = take | ~idle;
        irq_mask      = trace_on;
        swi_evt_block = trace_on;
    end

    trace_trap_gate #(
        .XLEN      (XLEN),
        .TRACE_BIT (TRACE_BIT)
    ) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .idle        (idle),
        .ret_valid   (ret_valid),
        .ret_dbranch (ret_dbranch),
        .ret_in_slot (ret_in_slot),
        .ret_excl    (ret_excl),
        .ps_in       (ps_in),
        .trace_on    (trace_on),
        .take        (take)
    );

    trace_trap_ctl #(
        .XLEN (XLEN)
    ) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take),
        .ps_in      (ps_in),
        .next_pc_in (ret_next_pc),
        .ssp_in     (ssp_in),
        .tbr_in     (tbr_in),
        .state      (state),
        .ps_q       (ps_q),
        .ra_q       (ra_q),
        .ssp_q      (ssp_q),
        .tbr_q      (tbr_q)
    );

    trace_trap_frame #(
        .XLEN        (XLEN),
        .STK_SEL_BIT (STK_SEL_BIT),
        .VEC_OFFSET  (VEC_OFFSET)
    ) u_frame (
        .state         (state),
        .ps_q          (ps_q),
        .ra_q          (ra_q),
        .ssp_q         (ssp_q),
        .tbr_q         (tbr_q),
        .stk_we        (stk_we),
        .stk_addr      (stk_addr),
        .stk_wdata     (stk_wdata),
        .ssp_we        (ssp_we),
        .ssp_out       (ssp_out),
        .ps_we         (ps_we),
        .ps_out        (ps_out),
        .pc_we         (pc_we),
        .pc_out        (pc_out),
        .handler_enter (handler_enter)
    );

endmodule

// File: rtl/trace_trap_chk.sv
// Protocol checker for trace_trap_seq, attached through bind. Observes ports only.
module trace_trap_chk #(
    parameter int XLEN        = 32,
    parameter int STK_SEL_BIT = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ret_valid,
    input logic            ret_dbranch,
    input logic            ret_excl,
    input logic            stk_we,
    input logic [XLEN-1:0] stk_addr,
    input logic            ssp_we,
    input logic [XLEN-1:0] ssp_out,
    input logic            ps_we,
    input logic [XLEN-1:0] ps_out,
    input logic            pc_we,
    input logic            handler_enter,
    input logic            stall
);

    // R6: the second push follows the first, one word lower.
    assert_push_descends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stk_we) |=> stk_we && (stk_addr == $past(stk_addr) - XLEN'(4)));

    // R7: redirect comes right after two pushes, lands SSP at the last push, clears stack-select.
    assert_redirect_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we |-> $past(stk_we) && $past(stk_we, 2) && ssp_we && ps_we &&
                  (ssp_out == $past(stk_addr)) && !ps_out[STK_SEL_BIT]);

    // R7: handler entry is a single-cycle pulse.
    assert_enter_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        handler_enter |=> !handler_enter);

    // R8: every write of the sequence happens under stall, never two kinds at once.
    assert_writes_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_we || pc_we) |-> stall && $onehot0({stk_we, pc_we}));

    // R8: with no stall, the next cycle carries no push.
    assert_idle_no_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |=> !stk_we);

    // R3: a retiring delayed branch never starts a trap.
    assert_branch_deferred_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_dbranch && !stk_we && !pc_we) |-> !stall);

    // R4: excluded retirements never start a trap.
    assert_excl_no_trap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_excl && !stk_we && !pc_we) |-> !stall);

endmodule

bind trace_trap_seq trace_trap_chk #(
    .XLEN        (XLEN),
    .STK_SEL_BIT (STK_SEL_BIT)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ret_valid     (ret_valid),
    .ret_dbranch   (ret_dbranch),
    .ret_excl      (ret_excl),
    .stk_we        (stk_we),
    .stk_addr      (stk_addr),
    .ssp_we        (ssp_we),
    .ssp_out       (ssp_out),
    .ps_we         (ps_we),
    .ps_out        (ps_out),
    .pc_we         (pc_we),
    .handler_enter (handler_enter),
    .stall         (stall)
);

// File: tb/trace_trap_seq_tb.sv
`timescale 1ns/1ps
// Self-checking bench for trace_trap_seq: vector table walk, then directed cases.
module trace_trap_seq_tb;

    localparam time         TCK = 4ns;
    localparam logic [31:0] VEC = 32'h0000_03C4;
    localparam logic [31:0] SEL = 32'h0000_0020;
    localparam int          NV  = 8;

    typedef struct packed {
        logic [31:0] ps;
        logic [31:0] npc;
        logic [31:0] ssp;
        logic [31:0] tbr;
        logic        dbr;
        logic        slot;
        logic        excl;
        logic        trap;
    } vec_t;

    // Trace bit is 0x100, stack-select bit is 0x20.
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0120, 32'h0000_1000, 32'h0000_8000, 32'h0F00_0000, 1'b0, 1'b0, 1'b0, 1'b1}, // R1 traced
        '{32'h0000_0130, 32'h0000_1004, 32'h0000_7FF0, 32'h0F00_1000, 1'b0, 1'b0, 1'b0, 1'b1}, // R1 back to back
        '{32'h0000_0020, 32'h0000_1008, 32'h0000_7FF0, 32'h0F00_1000, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 trace off
        '{32'h0000_01A0, 32'h0000_1100, 32'h0000_7FE0, 32'h0F00_1000, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 branch
        '{32'h0000_0120, 32'h0000_2000, 32'h0000_7FE0, 32'h0F00_1000, 1'b0, 1'b1, 1'b0, 1'b1}, // R3 slot
        '{32'h0000_0120, 32'h0000_3000, 32'h0000_7FD0, 32'h0F00_1000, 1'b0, 1'b0, 1'b1, 1'b0}, // R4 excluded
        '{32'h0000_0120, 32'h0000_4000, 32'h0000_6000, 32'h0A00_0000, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 branch
        '{32'h0000_0020, 32'h0000_5000, 32'h0000_6000, 32'h0A00_0000, 1'b0, 1'b1, 1'b0, 1'b1}  // R3 owed trap
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ret_valid = 1'b0;
    logic [31:0] ret_next_pc = '0;
    logic        ret_dbranch = 1'b0;
    logic        ret_in_slot = 1'b0;
    logic        ret_excl = 1'b0;
    logic [31:0] ps_in = '0;
    logic [31:0] tbr_in = '0;
    logic [31:0] ssp_in = '0;
    logic        stk_we, ssp_we, ps_we, pc_we, handler_enter, stall, irq_mask, swi_evt_block;
    logic [31:0] stk_addr, stk_wdata, ssp_out, ps_out, pc_out;

    int n_chk = 0;
    int n_err = 0;

    always #(TCK/2) clk = ~clk;

    trace_trap_seq u_dut (
        .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_next_pc(ret_next_pc),
        .ret_dbranch(ret_dbranch), .ret_in_slot(ret_in_slot), .ret_excl(ret_excl),
        .ps_in(ps_in), .tbr_in(tbr_in), .ssp_in(ssp_in),
        .stk_we(stk_we), .stk_addr(stk_addr), .stk_wdata(stk_wdata),
        .ssp_we(ssp_we), .ssp_out(ssp_out), .ps_we(ps_we), .ps_out(ps_out),
        .pc_we(pc_we), .pc_out(pc_out), .handler_enter(handler_enter),
        .stall(stall), .irq_mask(irq_mask), .swi_evt_block(swi_evt_block)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Follow the three entry phases of a trap, sampling mid-cycle.
    task automatic follow_trap(vec_t v);
        chk("R5", "push1 we",   32'(stk_we), 32'd1);
        chk("R5", "push1 addr", stk_addr, v.ssp - 32'd4);
        chk("R5", "push1 data", stk_wdata, v.ps);
        chk("R8", "stall p1",   32'(stall), 32'd1);
        @(negedge clk);
        chk("R6", "push2 we",   32'(stk_we), 32'd1);
        chk("R6", "push2 addr", stk_addr, v.ssp - 32'd8);
        chk("R6", "push2 data", stk_wdata, v.npc);
        @(negedge clk);
        chk("R7", "pc_we",      32'(pc_we), 32'd1);
        chk("R7", "pc_out",     pc_out, v.tbr + VEC);
        chk("R7", "ssp_out",    ssp_out, v.ssp - 32'd8);
        chk("R7", "ps_out",     ps_out, v.ps & ~SEL);
        chk("R7", "enter",      32'(handler_enter), 32'd1);
        chk("R8", "stall redir", 32'(stall), 32'd1);
        @(negedge clk);
        chk("R7", "enter pulse", 32'(handler_enter), 32'd0);
        chk("R8", "stall done",  32'(stall), 32'd0);
        chk("R8", "no extra push", 32'(stk_we), 32'd0);
    endtask

    // Present one retirement for one cycle and check the outcome.
    task automatic retire(vec_t v, string req);
        @(negedge clk);
        ps_in = v.ps; ret_next_pc = v.npc; ssp_in = v.ssp; tbr_in = v.tbr;
        ret_dbranch = v.dbr; ret_in_slot = v.slot; ret_excl = v.excl;
        ret_valid = 1'b1;
        #1;
        chk(req, "stall at decision", 32'(stall), 32'(v.trap));
        @(negedge clk);
        ret_valid = 1'b0; ret_dbranch = 1'b0; ret_in_slot = 1'b0; ret_excl = 1'b0;
        if (v.trap) begin
            follow_trap(v);
        end else begin
            chk(req, "no push", 32'(stk_we), 32'd0);
            chk(req, "no stall", 32'(stall), 32'd0);
        end
    endtask

    initial begin
        #(TCK * 200000);
        n_err++;
        $display("FAIL R8 watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        vec_t v;
        repeat (3) @(negedge clk);
        // R10: outputs quiet while in reset.
        chk("R10", "stk_we rst", 32'(stk_we), 32'd0);
        chk("R10", "pc_we rst",  32'(pc_we), 32'd0);
        chk("R10", "stall rst",  32'(stall), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "enter after rst", 32'(handler_enter), 32'd0);
        chk("R10", "ssp_we after rst", 32'(ssp_we), 32'd0);
        // R10: an untraced slot just after reset finds no owed trap.
        v = '{32'h0, 32'h0000_0500, 32'h0000_8000, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0};
        retire(v, "R10");

        for (int i = 0; i < NV; i++) begin
            retire(VECS[i], (i < 2) ? "R1" : (i == 2) ? "R2" : (i == 5) ? "R4" : "R3");
        end

        // R8: a retirement offered mid-sequence is ignored.
        v = '{32'h0000_0100, 32'h0000_6000, 32'h0000_9000, 32'h0100_0000, 1'b0, 1'b0, 1'b0, 1'b1};
        @(negedge clk);
        ps_in = v.ps; ret_next_pc = v.npc; ssp_in = v.ssp; tbr_in = v.tbr; ret_valid = 1'b1;
        @(negedge clk);
        ret_next_pc = 32'hDEAD_BEE0; ssp_in = 32'h0000_1234; ps_in = 32'h0000_01FF;
        chk("R8", "busy push1 data", stk_wdata, v.ps);
        @(negedge clk);
        ret_valid = 1'b0;
        chk("R8", "busy push2 data", stk_wdata, v.npc);
        chk("R8", "busy push2 addr", stk_addr, v.ssp - 32'd8);
        @(negedge clk);
        chk("R8", "busy pc_out", pc_out, v.tbr + VEC);
        @(negedge clk);
        chk("R8", "no second trap", 32'(stk_we), 32'd0);

        // R4: traced retirement inside the handler takes no trap.
        v = '{32'h0000_0100, 32'h0000_7000, 32'h0000_9000, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0};
        retire(v, "R4");

        // R9: interrupt and software-event masks follow the trace bit.
        @(negedge clk);
        ps_in = 32'h0000_0100;
        #1;
        chk("R9", "irq_mask on", 32'(irq_mask), 32'd1);
        chk("R9", "swi block on", 32'(swi_evt_block), 32'd1);
        ps_in = 32'hFFFF_FEFF;
        #1;
        chk("R9", "irq_mask off", 32'(irq_mask), 32'd0);
        chk("R9", "swi block off", 32'(swi_evt_block), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule